// File: doc/BRIEF.md
# Time Base and Watchdog Generator

This block takes a 32.768 kHz clock-enable and produces two timing events from it. The first is a periodic square wave whose rate is set by a 3-bit code, anywhere from 1 Hz to 128 Hz. The second is a sticky watchdog flag that sets once four periods of that square wave have passed without a watchdog clear. Both are built on one shared counting chain. Its low eight bits form a /256 prescaler, its upper bits form the time-base divider, and a small /4 stage after the selected tap acts as the watchdog.

A command decoder upstream drives the block with single-cycle strobes. There are strobes to enable, disable and clear the timer; to enable, disable and clear the watchdog; to enable and disable the interrupt; and to load a new rate code. The block drives an active-low interrupt pin. That pin is modelled as an open-drain pull-down enable, so 1 means the pin is pulled low. The pin reports the time-base wave, the watchdog flag, or both combined by OR, and only while interrupts are enabled. The raw square wave is also available on its own output.

Top module: `timebase_watchdog`

## Requirements
- R1: After reset, the timer, the watchdog and the interrupt are all disabled, the rate code is 7 (128 Hz), `irqPullLow` is 0 and `tbWave` is 0.
- R2: Let n be the number of enabled ticks since the last timer clear, taken modulo 2^15, and let c be the rate code. Then `tbWave` equals bit (14 - c) of n. Codes 0 to 7 therefore give 1, 2, 4, 8, 16, 32, 64 and 128 Hz, with the wave high in the second half of each period.
- R3: A cycle with `tickEn` low advances nothing. `tbWave` holds unless a timer clear or a rate load arrives in that cycle.
- R4: A timer clear resets the whole counting chain (prescaler and divider) to zero, so `tbWave` is 0 in the next cycle.
- R5: If the watchdog is enabled and the timer and the watchdog are cleared in the same cycle, the watchdog flag sets after exactly 4·P enabled ticks, where P = 2^(15 - c). It is not set after 4·P - 1 ticks.
- R6: Once set, the watchdog flag stays set until a watchdog clear or an interrupt disable. Either one clears it for the next cycle, and re-enabling the interrupt does not bring it back.
- R7: `irqPullLow` is 1 exactly when the interrupt is enabled and at least one of these holds: the timer is enabled and `tbWave` is 1, or the watchdog is enabled and its flag is set.
- R8: The controls act independently. A watchdog clear does not disturb the time-base count, and the watchdog times out while the timer is disabled.
- R9: If an enable and a disable strobe for the same function arrive in the same cycle, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 32.768 kHz clock-enable; one counting step per high cycle |
| cmdTimerEn | input | 1 | Strobe: enable time-base reporting on the interrupt |
| cmdTimerDis | input | 1 | Strobe: disable time-base reporting |
| cmdTimerClr | input | 1 | Strobe: clear prescaler and time-base divider |
| cmdWdtEn | input | 1 | Strobe: enable the watchdog |
| cmdWdtDis | input | 1 | Strobe: disable the watchdog |
| cmdWdtClr | input | 1 | Strobe: clear the /4 watchdog stage and its flag |
| cmdIrqEn | input | 1 | Strobe: enable the interrupt output |
| cmdIrqDis | input | 1 | Strobe: disable the interrupt output and clear the watchdog flag |
| cmdRateLd | input | 1 | Strobe: load `cmdRate` as the new rate code |
| cmdRate | input | 3 | Rate code, 0 = 1 Hz up to 7 = 128 Hz |
| tbWave | output | 1 | Selected time-base square wave |
| irqPullLow | output | 1 | Open-drain enable for the active-low interrupt pin (1 = pull low) |

## Verification
Some behaviours are checked on every cycle by the assertions. These are the freeze when `tickEn` is low, the wave dropping right after a timer clear, the stickiness of the watchdog flag, its clearing by either clear path, the interrupt going quiet after a disable, and the quiet state out of reset. Other behaviours can only be shown by the bench's scenarios. These are the exact tick on which each rate code toggles, the exact 4·P timeout at several rates, the OR of both sources on the interrupt, the independence of watchdog clears from the time-base count, and the priority of a disable over an enable in the same cycle.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int PRE_W  = 8;                  // /256 prescaler
  localparam int TB_W   = 7;                  // time-base divider stages
  localparam int WDT_W  = 2;                  // /4 watchdog stage
  localparam int RATE_W = $clog2(TB_W + 1);   // one code per tap

  typedef struct packed {
    logic              clrTimer;
    logic              clrWdt;
    logic              clrFlag;
    logic              wdtRun;
    logic [RATE_W-1:0] rate;
  } tbwStrobes_t;
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdTimerEn,
  input  logic              cmdTimerDis,
  input  logic              cmdTimerClr,
  input  logic              cmdWdtEn,
  input  logic              cmdWdtDis,
  input  logic              cmdWdtClr,
  input  logic              cmdIrqEn,
  input  logic              cmdIrqDis,
  input  logic              cmdRateLd,
  input  logic [RATE_W-1:0] cmdRate,
  input  logic              tbWave,
  input  logic              wdtFlag,
  output tbwStrobes_t       strb,
  output logic              irqPullLow
);
  logic              timerOn;
  logic              wdtOn;
  logic              irqOn;
  logic [RATE_W-1:0] rateSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerOn <= 1'b0;
      wdtOn   <= 1'b0;
      irqOn   <= 1'b0;
      rateSel <= '1;
    end else begin
      if (cmdTimerDis)     timerOn <= 1'b0;
      else if (cmdTimerEn) timerOn <= 1'b1;
      if (cmdWdtDis)       wdtOn   <= 1'b0;
      else if (cmdWdtEn)   wdtOn   <= 1'b1;
      if (cmdIrqDis)       irqOn   <= 1'b0;
      else if (cmdIrqEn)   irqOn   <= 1'b1;
      if (cmdRateLd)       rateSel <= cmdRate;
    end
  end

  always_comb begin
    strb.clrTimer = cmdTimerClr;
    strb.clrWdt   = cmdWdtClr;
    strb.clrFlag  = cmdWdtClr | cmdIrqDis;
    strb.wdtRun   = wdtOn;
    strb.rate     = rateSel;
  end

  assign irqPullLow = irqOn & ((timerOn & tbWave) | (wdtOn & wdtFlag));
endmodule

// File: rtl/tbw_datapath.sv
module tbw_datapath
  import tbw_pkg::*;
#(
  parameter int PRESCALE_W = PRE_W,
  parameter int DIVIDER_W  = TB_W,
  parameter int WATCHDOG_W = WDT_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  tbwStrobes_t strb,
  output logic        tbWave,
  output logic        wdtFlag
);
  localparam int CNT_W = PRESCALE_W + DIVIDER_W;
  localparam int IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0]      chain;
  logic [WATCHDOG_W-1:0] wdtCnt;
  logic [IDX_W-1:0]      tapIdx;
  logic [CNT_W-1:0]      tapMask;
  logic                  periodEnd;

  // code c selects bit (CNT_W-1-c): highest code is the fastest tap
  assign tapIdx    = IDX_W'(CNT_W - 1) - IDX_W'(strb.rate);
  assign tapMask   = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << ({1'b0, tapIdx} + 1'b1)) - 1'b1);
  assign tbWave    = chain[tapIdx];
  assign periodEnd = tickEn & ~strb.clrTimer & ((chain & tapMask) == tapMask);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrTimer) chain <= '0;
    else if (tickEn)            chain <= chain + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrWdt || !strb.wdtRun) wdtCnt <= '0;
    else if (periodEnd)                       wdtCnt <= wdtCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrFlag)                   wdtFlag <= 1'b0;
    else if (strb.wdtRun && periodEnd && &wdtCnt) wdtFlag <= 1'b1;
  end
endmodule

// File: rtl/timebase_watchdog.sv
module timebase_watchdog
  import tbw_pkg::*;
#(
  parameter int PRESCALE_W = PRE_W,
  parameter int DIVIDER_W  = TB_W,
  parameter int WATCHDOG_W = WDT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cmdTimerEn,
  input  logic              cmdTimerDis,
  input  logic              cmdTimerClr,
  input  logic              cmdWdtEn,
  input  logic              cmdWdtDis,
  input  logic              cmdWdtClr,
  input  logic              cmdIrqEn,
  input  logic              cmdIrqDis,
  input  logic              cmdRateLd,
  input  logic [RATE_W-1:0] cmdRate,
  output logic              tbWave,
  output logic              irqPullLow
);
  tbwStrobes_t strb;
  logic        wdtFlag;

  tbw_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdTimerEn(cmdTimerEn), .cmdTimerDis(cmdTimerDis), .cmdTimerClr(cmdTimerClr),
    .cmdWdtEn(cmdWdtEn), .cmdWdtDis(cmdWdtDis), .cmdWdtClr(cmdWdtClr),
    .cmdIrqEn(cmdIrqEn), .cmdIrqDis(cmdIrqDis),
    .cmdRateLd(cmdRateLd), .cmdRate(cmdRate),
    .tbWave(tbWave), .wdtFlag(wdtFlag),
    .strb(strb), .irqPullLow(irqPullLow)
  );

  tbw_datapath #(
    .PRESCALE_W(PRESCALE_W), .DIVIDER_W(DIVIDER_W), .WATCHDOG_W(WATCHDOG_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb),
    .tbWave(tbWave), .wdtFlag(wdtFlag)
  );
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic cmdTimerClr,
  input logic cmdWdtClr,
  input logic cmdIrqDis,
  input logic cmdRateLd,
  input logic tbWave,
  input logic wdtFlag,
  input logic irqPullLow
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN) $rose(rstN) |-> (!irqPullLow && !wdtFlag)); // R1
  AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rstN) (!tickEn && !cmdTimerClr && !cmdRateLd) |=> $stable(tbWave)); // R3
  AST_CLR_WAVE_LOW: assert property (@(posedge clk) disable iff (!rstN) cmdTimerClr |=> !tbWave); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN) (wdtFlag && !cmdWdtClr && !cmdIrqDis) |=> wdtFlag); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (cmdWdtClr || cmdIrqDis) |=> !wdtFlag); // R6
  AST_IRQ_DIS_QUIET: assert property (@(posedge clk) disable iff (!rstN) cmdIrqDis |=> !irqPullLow); // R7
endmodule

bind timebase_watchdog tbw_checker uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn),
  .cmdTimerClr(cmdTimerClr), .cmdWdtClr(cmdWdtClr), .cmdIrqDis(cmdIrqDis),
  .cmdRateLd(cmdRateLd), .tbWave(tbWave), .wdtFlag(wdtFlag), .irqPullLow(irqPullLow)
);

// File: tb/sim_timebase_watchdog.sv
`timescale 1ns/1ps
module sim_timebase_watchdog;
  localparam int TEN = 0, TDIS = 1, TCLR = 2, WEN = 3, WDIS = 4, WCLR = 5, IEN = 6, IDIS = 7, RLD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [8:0] cmdVec = '0;
  logic [2:0] cmdRate = '0;
  logic       tbWave, irqPullLow;

  int errors = 0, checks = 0;
  int refN = 0;
  int benchRate = 7;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timebase_watchdog u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cmdTimerEn(cmdVec[TEN]), .cmdTimerDis(cmdVec[TDIS]), .cmdTimerClr(cmdVec[TCLR]),
    .cmdWdtEn(cmdVec[WEN]), .cmdWdtDis(cmdVec[WDIS]), .cmdWdtClr(cmdVec[WCLR]),
    .cmdIrqEn(cmdVec[IEN]), .cmdIrqDis(cmdVec[IDIS]),
    .cmdRateLd(cmdVec[RLD]), .cmdRate(cmdRate),
    .tbWave(tbWave), .irqPullLow(irqPullLow)
  );

  // reference tick count since the last timer clear (from R2/R4)
  always @(posedge clk) begin
    if (!rstN || cmdVec[TCLR]) refN <= 0;
    else if (tickEn)           refN <= refN + 1;
  end

  function automatic logic expWave(input int n, input int r);
    return logic'(((n % 32768) >> (14 - r)) & 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (n=%0d rate=%0d)", req, act, exp, refN, benchRate);
    end
  endtask

  task automatic strobe(input logic [8:0] v, input int r);
    @(negedge clk);
    cmdVec = v;
    cmdRate = 3'(r);
    @(negedge clk);
    cmdVec = '0;
    if (v[RLD]) benchRate = r;
  endtask

  task automatic waitN(input int m);
    while (refN != m) @(negedge clk);
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 irq", irqPullLow, 1'b0);
    check("R1 wave", tbWave, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after release", irqPullLow, 1'b0);

    // R1/R2: default rate 128 Hz, period 256 ticks
    tickEn = 1'b1;
    strobe(9'(1 << TCLR), 0);
    waitN(127); check("R1 default rate low", tbWave, 1'b0);
    waitN(128); check("R1 default rate high", tbWave, 1'b1);
    waitN(255); check("R2 r7 end high", tbWave, 1'b1);
    waitN(256); check("R2 r7 wrap low", tbWave, 1'b0);

    // R2/R3: random rates, random tick gating
    for (int i = 0; i < 40; i++) begin
      int r, w;
      r = (i % 5 == 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(3, 7));
      strobe(9'(1 << RLD), r);
      w = int'($urandom_range(1, 600));
      for (int k = 0; k < w; k++) begin
        @(negedge clk);
        tickEn = ($urandom_range(0, 3) != 0);
      end
      @(negedge clk);
      check("R2 random rate wave", tbWave, expWave(refN, benchRate));
    end
    tickEn = 1'b1;

    // R3: freeze with tickEn low
    strobe(9'(1 << RLD), 7);
    strobe(9'(1 << TCLR), 7);
    waitN(200);
    tickEn = 1'b0;
    repeat (50) @(negedge clk);
    check("R3 frozen count", logic'(refN == 200), 1'b1);
    check("R3 frozen wave", tbWave, 1'b1);
    tickEn = 1'b1;

    // R4: timer clear while wave high
    strobe(9'(1 << TCLR), 7);
    check("R4 clear low", tbWave, 1'b0);

    // R7: timer reported on irq; R9: disable beats enable
    strobe(9'((1 << TEN) | (1 << IEN)), 7);
    waitN(140); check("R7 irq follows wave high", irqPullLow, 1'b1);
    waitN(260); check("R7 irq follows wave low", irqPullLow, 1'b0);
    strobe(9'((1 << TEN) | (1 << TDIS)), 7);
    waitN(400); check("R9 disable wins", irqPullLow, 1'b0);

    // R8: watchdog clear does not disturb the time base
    strobe(9'(1 << TCLR), 7);
    waitN(100);
    strobe(9'(1 << WCLR), 7);
    waitN(130); check("R8 wdt clear keeps count", tbWave, 1'b1);

    // R5/R8: watchdog at 128 Hz with timer disabled
    strobe(9'(1 << WEN), 7);
    strobe(9'((1 << TCLR) | (1 << WCLR)), 7);
    waitN(1023); check("R5 r7 before timeout", irqPullLow, 1'b0);
    waitN(1024); check("R5 r7 at timeout", irqPullLow, 1'b1);
    waitN(3000); check("R6 flag sticky", irqPullLow, 1'b1);
    strobe(9'(1 << WCLR), 7);
    check("R6 wdt clear drops irq", irqPullLow, 1'b0);

    // R5 at 32 Hz
    strobe(9'(1 << RLD), 5);
    strobe(9'((1 << TCLR) | (1 << WCLR)), 5);
    waitN(4095); check("R5 r5 before timeout", irqPullLow, 1'b0);
    waitN(4096); check("R5 r5 at timeout", irqPullLow, 1'b1);

    // R7: both sources OR'd
    strobe(9'(1 << TEN), 5);
    waitN(4196); check("R7 OR with wave low", irqPullLow, 1'b1);
    strobe(9'(1 << IDIS), 5);
    check("R6 irq disable drops irq", irqPullLow, 1'b0);
    strobe(9'(1 << IEN), 5);
    waitN(4696); check("R6 flag gone, wave high", irqPullLow, 1'b1);
    waitN(5200); check("R6 flag gone, wave low", irqPullLow, 1'b0);

    // R5 at 8 Hz
    strobe(9'((1 << TDIS) | (1 << RLD)), 3);
    strobe(9'((1 << TCLR) | (1 << WCLR)), 3);
    waitN(16383); check("R5 r3 before timeout", irqPullLow, 1'b0);
    waitN(16384); check("R5 r3 at timeout", irqPullLow, 1'b1);
    strobe(9'(1 << WDIS), 3);
    check("R7 wdt disabled quiet", irqPullLow, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule